// File: doc/BRIEF.md
# Dual-XOR Clock/Data Decision and Phase Detector

This block retimes an oversampled serial data stream with a bit-rate sampling enable, and reports digital measurements of how the sampling point sits within the bit. The design runs on a fast clock that is `OVS` times the bit rate. A phase counter that runs freely produces one sampling enable per bit period, at a tick position chosen by `phase_ofs`. Two bit-rate flops in series capture the data. The first flop gives the retimed data output.

Two XOR comparisons form the detector. The first compares the live input with the first flop, so its high time per transition grows with the distance from the bit edge to the sampling instant. The second compares the two flops, which are one bit apart, so its high time per transition is always one full bit period. That makes it a reference that depends only on transition density. The high ticks of both XORs, and of the regenerated bit-rate clock, are integrated over a programmable window of bit periods. At the end of the window they are latched and presented with a one-cycle strobe. Also latched are a signed phase error (first count minus half the reference) and a flag for a window that held no transitions.

Top module: `dual_xor_phase_det`

## Requirements
- R1: On each sampling enable the first flop loads `din` and the second flop loads the first flop. `dout` is the first flop, so it changes only on the clock edge that ends the enable tick.
- R2: After reset the tick counter starts at 0 in the first cycle and wraps every `OVS` ticks. The sampling enable occurs in the tick whose count equals `phase_ofs`, so it comes once per bit period.
- R3: `cnt_phase` counts the ticks of a window in which `din` differs from `dout`. With bit edges at tick 0, each data transition adds `phase_ofs + 1` ticks.
- R4: `cnt_ref` counts the ticks of a window in which the two flops differ. Each transition adds exactly `OVS` ticks, whatever the value of `phase_ofs`.
- R5: A window spans `win_bits` bit periods, and a value of 0 acts as 1. The window closes on a sampling-enable edge. All results update on that edge, and `meas_valid` is high for exactly the following cycle.
- R6: `phase_err` is the signed value `cnt_phase - cnt_ref/2`. With transitions every bit it is 0 when `phase_ofs = OVS/2 - 1`, negative for earlier sampling and positive for later sampling.
- R7: `no_trans` is 1 when the latched `cnt_ref` is 0. Constant data then gives zero for both counts and for `phase_err`.
- R8: `clk_out` is low from reset until the first sampling enable. After each enable it is high for `OVS/2` ticks starting the next tick, then low. `cnt_duty` counts its high ticks per window, which is `win_bits*OVS/2` in steady state.
- R9: Reset (synchronous, active high) clears `dout`, `meas_valid`, `clk_out`, all counts, `phase_err` and `no_trans`.
- R10: No window accumulator ever wraps. The count width covers a full window plus one stretched bit period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, `OVS` ticks per bit |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial data, sampled each tick |
| phase_ofs | input | PH_W | Tick within the bit period at which data is sampled |
| win_bits | input | WIN_W | Window length in bit periods (0 acts as 1) |
| dout | output | 1 | Retimed data (first flop) |
| clk_out | output | 1 | Regenerated bit-rate clock |
| meas_valid | output | 1 | One-cycle strobe: new window results |
| cnt_phase | output | CNT_W | Ticks of data-versus-retimed mismatch in last window |
| cnt_ref | output | CNT_W | Ticks of one-bit-delay mismatch in last window |
| cnt_duty | output | CNT_W | High ticks of `clk_out` in last window |
| phase_err | output | CNT_W+1 | Signed `cnt_phase - cnt_ref/2` |
| no_trans | output | 1 | Last window carried no data transitions |

## Verification
The sampling enable that loads the flops can be the same edge that closes a window. In that cycle, three things land on one edge: the final XOR samples are added to the accumulators, the results are latched, and the accumulators are cleared. The single-bit window (`win_bits` = 0) forces this coincidence on every enable. Its results must still show exactly `phase_ofs + 1` phase ticks and `OVS` reference ticks, which would reveal a lost or doubled tick at the boundary. The sweeps of `phase_ofs` at the extremes and at mid-bit judge the same boundary against the closed-form counts for alternating and two-bit-run patterns.

// File: rtl/cdpd_pkg.sv
package cdpd_pkg;

    // Per-tick event bundle fed from the retimer and timer to the integrator
    typedef struct packed {
        logic clk_high;   // regenerated clock is high this tick
        logic edge_ref;   // first and second flop disagree
        logic edge_data;  // live input and first flop disagree
    } cdpd_events_t;

    localparam int NUM_EVENTS = 3;

    function automatic int half_of(input int v);
        return v / 2;
    endfunction

endpackage

// File: rtl/cdpd_bit_timer.sv
module cdpd_bit_timer #(
    parameter int OVS  = 8,
    parameter int PH_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PH_W-1:0] phase_ofs,
    output logic            bit_en,
    output logic            clk_out
);
    localparam int HALF = cdpd_pkg::half_of(OVS);
    localparam logic [PH_W-1:0] LAST = PH_W'(OVS - 1);

    logic [PH_W-1:0] tick_q;
    logic [PH_W-1:0] since_q;   // ticks since last sampling enable, saturating

    assign bit_en  = (tick_q == phase_ofs);
    assign clk_out = (since_q < PH_W'(HALF));

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q  <= '0;
            since_q <= LAST;
        end else begin
            tick_q  <= (tick_q == LAST) ? '0 : tick_q + 1'b1;
            if (bit_en)
                since_q <= '0;
            else if (since_q != LAST)
                since_q <= since_q + 1'b1;
        end
    end

    // R2: enable is never high in two consecutive ticks
    assert_single_enable_R2: assert property (@(posedge clk) disable iff (rst)
        bit_en |=> !bit_en);

    // R8: regenerated clock only rises right after a sampling enable
    assert_clk_rise_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_out) |-> $past(bit_en));

endmodule

// File: rtl/cdpd_retimer.sv
module cdpd_retimer (
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic din,
    output logic dout,
    output logic edge_data,
    output logic edge_ref
);
    logic stage1_q;
    logic stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= 1'b0;
            stage2_q <= 1'b0;
        end else if (bit_en) begin
            stage1_q <= din;
            stage2_q <= stage1_q;
        end
    end

    assign dout      = stage1_q;
    assign edge_data = din ^ stage1_q;
    assign edge_ref  = stage1_q ^ stage2_q;

    // R1: first flop holds between sampling enables
    assert_hold_between_R1: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(stage1_q));

    // R1: second flop takes the old first-flop value on each enable
    assert_shift_chain_R1: assert property (@(posedge clk) disable iff (rst)
        bit_en |=> stage2_q == $past(stage1_q));

endmodule

// File: rtl/cdpd_window.sv
module cdpd_window #(
    parameter int WIN_W = 6,
    parameter int CNT_W = 10
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bit_en,
    input  logic [WIN_W-1:0]         win_bits,
    input  cdpd_pkg::cdpd_events_t   ev,
    output logic                     meas_valid,
    output logic [CNT_W-1:0]         cnt_phase,
    output logic [CNT_W-1:0]         cnt_ref,
    output logic [CNT_W-1:0]         cnt_duty,
    output logic signed [CNT_W:0]    phase_err,
    output logic                     no_trans
);
    localparam int NE = cdpd_pkg::NUM_EVENTS;

    logic [NE-1:0]    ev_v;
    logic [CNT_W-1:0] acc_q [NE];
    logic [CNT_W-1:0] sum   [NE];
    logic [CNT_W-1:0] lat_q [NE];
    logic [WIN_W-1:0] bit_idx_q;
    logic             last_bit;
    logic             close_win;
    logic signed [CNT_W:0] err_d;
    logic             valid_q;
    logic signed [CNT_W:0] err_q;
    logic             none_q;

    assign ev_v      = ev;
    assign last_bit  = ({1'b0, bit_idx_q} + 1'b1) >= {1'b0, win_bits};
    assign close_win = bit_en && last_bit;

    for (genvar i = 0; i < NE; i++) begin : g_acc
        assign sum[i] = acc_q[i] + {{(CNT_W-1){1'b0}}, ev_v[i]};

        always_ff @(posedge clk) begin
            if (rst) begin
                acc_q[i] <= '0;
                lat_q[i] <= '0;
            end else if (close_win) begin
                acc_q[i] <= '0;
                lat_q[i] <= sum[i];
            end else begin
                acc_q[i] <= sum[i];
            end
        end

        // R10: accumulator never wraps within a window
        assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
            !(acc_q[i] == {CNT_W{1'b1}} && ev_v[i]));
    end

    assign err_d = $signed({1'b0, sum[0]}) - $signed({2'b00, sum[1][CNT_W-1:1]});

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_idx_q <= '0;
            valid_q   <= 1'b0;
            err_q     <= '0;
            none_q    <= 1'b0;
        end else begin
            valid_q <= close_win;
            if (bit_en)
                bit_idx_q <= last_bit ? '0 : bit_idx_q + 1'b1;
            if (close_win) begin
                err_q  <= err_d;
                none_q <= (sum[1] == '0);
            end
        end
    end

    assign meas_valid = valid_q;
    assign cnt_phase  = lat_q[0];
    assign cnt_ref    = lat_q[1];
    assign cnt_duty   = lat_q[2];
    assign phase_err  = err_q;
    assign no_trans   = none_q;

    // R5: result strobe lasts a single cycle
    assert_strobe_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q);

    // R5: latched results move only on a window close
    assert_results_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !close_win |=> $stable(lat_q[0]) && $stable(err_q));

endmodule

// File: rtl/dual_xor_phase_det.sv
module dual_xor_phase_det #(
    parameter int OVS   = 8,
    parameter int WIN_W = 6,
    parameter int PH_W  = $clog2(OVS),
    parameter int CNT_W = WIN_W + PH_W + 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  din,
    input  logic [PH_W-1:0]       phase_ofs,
    input  logic [WIN_W-1:0]      win_bits,
    output logic                  dout,
    output logic                  clk_out,
    output logic                  meas_valid,
    output logic [CNT_W-1:0]      cnt_phase,
    output logic [CNT_W-1:0]      cnt_ref,
    output logic [CNT_W-1:0]      cnt_duty,
    output logic signed [CNT_W:0] phase_err,
    output logic                  no_trans
);
    logic                   bit_en;
    logic                   edge_data;
    logic                   edge_ref;
    cdpd_pkg::cdpd_events_t ev;

    cdpd_bit_timer #(.OVS(OVS), .PH_W(PH_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .phase_ofs (phase_ofs),
        .bit_en    (bit_en),
        .clk_out   (clk_out)
    );

    cdpd_retimer u_retime (
        .clk       (clk),
        .rst       (rst),
        .bit_en    (bit_en),
        .din       (din),
        .dout      (dout),
        .edge_data (edge_data),
        .edge_ref  (edge_ref)
    );

    always_comb begin
        ev.edge_data = edge_data;
        ev.edge_ref  = edge_ref;
        ev.clk_high  = clk_out;
    end

    cdpd_window #(.WIN_W(WIN_W), .CNT_W(CNT_W)) u_window (
        .clk        (clk),
        .rst        (rst),
        .bit_en     (bit_en),
        .win_bits   (win_bits),
        .ev         (ev),
        .meas_valid (meas_valid),
        .cnt_phase  (cnt_phase),
        .cnt_ref    (cnt_ref),
        .cnt_duty   (cnt_duty),
        .phase_err  (phase_err),
        .no_trans   (no_trans)
    );

endmodule

// File: tb/dual_xor_phase_det_tb.sv
`timescale 1ns/1ps
module dual_xor_phase_det_tb;
    localparam int OVS   = 8;
    localparam int WIN_W = 6;
    localparam int PH_W  = 3;
    localparam int CNT_W = WIN_W + PH_W + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic [PH_W-1:0]  ofs = '0;
    logic [WIN_W-1:0] win = 6'd8;
    logic [3:0]       pat = 4'b0000;
    int k = 0;

    logic dout, clk_out, meas_valid, no_trans;
    logic [CNT_W-1:0] cnt_phase, cnt_ref, cnt_duty;
    logic signed [CNT_W:0] phase_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    dual_xor_phase_det #(.OVS(OVS), .WIN_W(WIN_W)) u_dut (
        .clk(clk), .rst(rst), .din(din), .phase_ofs(ofs), .win_bits(win),
        .dout(dout), .clk_out(clk_out), .meas_valid(meas_valid),
        .cnt_phase(cnt_phase), .cnt_ref(cnt_ref), .cnt_duty(cnt_duty),
        .phase_err(phase_err), .no_trans(no_trans)
    );

    always #2 clk = ~clk;

    // data source: bit index k/OVS, bit edges at tick 0 of each period
    always @(negedge clk) begin
        if (rst) begin
            k   = 0;
            din = 1'b0;
        end else begin
            din = pat[(k / OVS) % 4];
            k   = k + 1;
        end
    end

    always @(posedge clk) begin
        cycles = cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    // Set stimulus, skip two settling windows, check the third
    task automatic measure(input string tag, input logic [3:0] p, input int o, input int w,
                           input int e_ph, input int e_ref, input int e_duty,
                           input int e_err, input int e_none);
        int seen;
        @(posedge clk);
        #1;
        pat = p;
        ofs = PH_W'(o);
        win = WIN_W'(w);
        seen = 0;
        while (seen < 3) begin
            @(negedge clk);
            if (meas_valid) seen = seen + 1;
        end
        chk({tag, " R3 cnt_phase"}, int'(cnt_phase), e_ph);
        chk({tag, " R4 cnt_ref"},   int'(cnt_ref),   e_ref);
        chk({tag, " R8 cnt_duty"},  int'(cnt_duty),  e_duty);
        chk({tag, " R6 phase_err"}, int'(phase_err), e_err);
        chk({tag, " R7 no_trans"},  int'(no_trans),  e_none);
        @(negedge clk);
        chk({tag, " R5 strobe width"}, int'(meas_valid), 0);
    endtask

    // R9 reset state, R1/R2 retime timing, R8 clock shape
    task automatic test_reset_and_timing();
        pat = 4'b1111;
        ofs = 3'd3;
        win = 6'd8;
        do_reset();
        for (int t = 0; t < 13; t++) begin
            @(negedge clk);
            if (t == 0) begin
                chk("R9 dout", int'(dout), 0);
                chk("R9 meas_valid", int'(meas_valid), 0);
                chk("R9 clk_out", int'(clk_out), 0);
                chk("R9 cnt_phase", int'(cnt_phase), 0);
                chk("R9 cnt_ref", int'(cnt_ref), 0);
                chk("R9 phase_err", int'(phase_err), 0);
                chk("R9 no_trans", int'(no_trans), 0);
            end
            chk($sformatf("R1 R2 dout cycle %0d", t), int'(dout), (t >= 4) ? 1 : 0);
            chk($sformatf("R8 clk_out cycle %0d", t), int'(clk_out),
                ((t >= 4 && t < 8) || t >= 12) ? 1 : 0);
        end
    endtask

    initial begin
        test_reset_and_timing();
        // alternating data, mid-bit sampling: balanced detector
        measure("alt mid",   4'b0101, 3, 8, 32, 64, 32,   0, 0);
        // earliest sampling point
        measure("alt early", 4'b0101, 0, 8,  8, 64, 32, -24, 0);
        // latest sampling point
        measure("alt late",  4'b0101, 7, 8, 64, 64, 32,  32, 0);
        // two-bit runs: half the transition density
        measure("runs",      4'b0011, 5, 8, 24, 32, 32,   8, 0);
        // single transition pair per four bits, early sampling
        measure("sparse",    4'b0001, 1, 8,  8, 32, 32,  -8, 0);
        // constant data: no phase information
        measure("const",     4'b0000, 2, 8,  0,  0, 32,   0, 1);
        // zero window length acts as one bit: enable and close coincide
        measure("win0",      4'b0101, 2, 0,  3,  8,  4,  -1, 0);
        measure("win1",      4'b1010, 6, 1,  7,  8,  4,   3, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule